// File: doc/BRIEF.md
# Comparator Enable and Output Routing Controller

This block is the digital side of four analog comparators. Each comparator reaches it as one asynchronous digital result. A control register holds one enable bit per comparator. Reading that register returns the enables in the upper half and the current results in the lower half. A routing register then decides, per comparator, whether the result triggers a timer capture input, drives an open-drain port pin, does both, or does neither.

The block gates every path by the power mode. In power-down all comparators are forced off. In idle the capture path is blocked and the pin path keeps working. A rising edge of any enabled result sets a sticky interrupt. That interrupt is what ends idle mode.

All interfaces are plain control and status pins with no data stream, so there is no valid/ready handshake. The register write strobes are single-cycle and need no back-pressure. Reads are combinational.

Top module: `cmp_route_ctrl`

## Requirements
- R1: After reset, both registers read zero, and every output (comparator enables, pull-up controls, capture triggers, pin pull-low, interrupt) is 0.
- R2: A write to the control register stores bits 7..4 as the enables of comparators 3..0 (bit 4+i enables comparator i). Bits 3..0 of the written data are ignored. A read returns the enables in bits 7..4 and the results in bits 3..0.
- R3: Result bit i (control read bit i) equals comparator input i, synchronised through two flops, so it appears after the second rising edge. It reads 0 while comparator i is not effectively enabled.
- R4: Comparator i is effectively enabled when its enable bit is 1 and power-down is low. In that state both `cmp_en_o[i]` and `in_pullup_off_o[i]` are 1.
- R5: While `pdown_i` is 1, no comparator is enabled, no result, capture trigger or pin drive is active, and the interrupt is not newly set. This holds whatever the register contents. Power-down takes precedence over idle.
- R6: `cap_trig_o[i]` is 1 exactly when result i is 1, routing bit 4+i is 1, and neither idle nor power-down is asserted.
- R7: `pin_pullup_off_o[i]` is 1 exactly when comparator i is effectively enabled, routing bit i is 1 and `port_latch_i[i]` is 1. While that holds, `pin_pull_low_o[i]` is the inverse of the synchronised result. Idle does not affect either output.
- R8: When routing bit i or port latch i is 0, both `pin_pullup_off_o[i]` and `pin_pull_low_o[i]` are 0, which leaves the pin to ordinary I/O.
- R9: A synchronised result going 0 to 1 on an effectively enabled comparator sets `irq_o` on the following rising edge. This also works in idle. `irq_o` holds until a cycle with `irq_clr_i` high, and a new edge in that same cycle takes priority over the clear.
- R10: All 8 bits of the routing register are writable and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Write strobe for the control register |
| rte_wr_i | input | 1 | Write strobe for the routing register |
| wr_data_i | input | 8 | Register write data |
| ctl_rd_o | output | 8 | Control register read: enables in bits 7..4, results in bits 3..0 |
| rte_rd_o | output | 8 | Routing register read: capture routes in bits 7..4, pin routes in bits 3..0 |
| cmp_raw_i | input | 4 | Asynchronous comparator results |
| port_latch_i | input | 4 | Port latch bits of the four comparator output pins |
| idle_i | input | 1 | Idle mode |
| pdown_i | input | 1 | Power-down mode |
| irq_clr_i | input | 1 | Clears the interrupt |
| cmp_en_o | output | 4 | Enables to the analog comparators |
| in_pullup_off_o | output | 4 | Turns off pull-ups on comparator input pins |
| cap_trig_o | output | 4 | Capture trigger per comparator |
| pin_pullup_off_o | output | 4 | Turns off pin pull-up; the pin is open drain |
| pin_pull_low_o | output | 4 | Pulls the open-drain pin low |
| irq_o | output | 1 | Sticky comparator interrupt |

## Verification
The assertions take the mode and latch inputs as stable between clock edges. They treat the comparator inputs as arbitrary and asynchronous, because only their synchronised copies are checked over time. Write strobes may coincide with any mode.

The stimulus changes every input only on the falling edge. It moves through run, idle, power-down and combined idle plus power-down phases while writing random register values and random comparator patterns. That covers enable changes that land on already-high results and clears that collide with new edges.

// File: rtl/cmp_route_pkg.sv
package cmp_route_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_DOWN = 2'd2
  } pmode_e;

  // Power-down dominates idle.
  function automatic pmode_e decode_mode(input logic idle, input logic pdown);
    if (pdown)     return PM_DOWN;
    else if (idle) return PM_IDLE;
    else           return PM_RUN;
  endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs #(
  parameter int unsigned N_CMP = 4,
  localparam int unsigned REG_W = 2 * N_CMP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_i,
  input  logic [N_CMP-1:0] ctl_data_i,
  input  logic             rte_wr_i,
  input  logic [REG_W-1:0] rte_data_i,
  output logic [N_CMP-1:0] en_bits_o,
  output logic [N_CMP-1:0] cap_route_o,
  output logic [N_CMP-1:0] pin_route_o
);
  logic [N_CMP-1:0] en_q;
  logic [REG_W-1:0] rte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (ctl_wr_i) en_q <= ctl_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rte_q <= '0;
    else if (rte_wr_i) rte_q <= rte_data_i;
  end

  assign en_bits_o   = en_q;
  assign cap_route_o = rte_q[REG_W-1:N_CMP];
  assign pin_route_o = rte_q[N_CMP-1:0];
endmodule

// File: rtl/cmp_route.sv
module cmp_route
  import cmp_route_pkg::*;
#(
  parameter int unsigned N_CMP = 4
) (
  input  pmode_e           mode_i,
  input  logic [N_CMP-1:0] en_bits_i,
  input  logic [N_CMP-1:0] cap_route_i,
  input  logic [N_CMP-1:0] pin_route_i,
  input  logic [N_CMP-1:0] latch_i,
  input  logic [N_CMP-1:0] res_sync_i,
  output logic [N_CMP-1:0] eff_en_o,
  output logic [N_CMP-1:0] res_o,
  output logic [N_CMP-1:0] cap_trig_o,
  output logic [N_CMP-1:0] pin_own_o,
  output logic [N_CMP-1:0] pin_low_o
);
  logic pwr_on, cap_allowed;

  always_comb begin
    pwr_on      = (mode_i != PM_DOWN);
    cap_allowed = (mode_i == PM_RUN);
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    always_comb begin
      eff_en_o[i]   = en_bits_i[i] & pwr_on;
      res_o[i]      = eff_en_o[i] & res_sync_i[i];
      cap_trig_o[i] = res_o[i] & cap_route_i[i] & cap_allowed;
      pin_own_o[i]  = eff_en_o[i] & pin_route_i[i] & latch_i[i];
      pin_low_o[i]  = pin_own_o[i] & ~res_sync_i[i];
    end
  end
endmodule

// File: rtl/cmp_irq.sv
module cmp_irq #(
  parameter int unsigned N_CMP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CMP-1:0] res_sync_i,
  input  logic [N_CMP-1:0] eff_en_i,
  input  logic             clr_i,
  output logic             irq_o
);
  logic [N_CMP-1:0] prev_q;
  logic [N_CMP-1:0] rise;
  logic             irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= res_sync_i;
  end

  always_comb rise = res_sync_i & ~prev_q & eff_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_q <= 1'b0;
    else if (|rise) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/cmp_route_ctrl.sv
module cmp_route_ctrl
  import cmp_route_pkg::*;
#(
  parameter int unsigned N_CMP       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned REG_W      = 2 * N_CMP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_i,
  input  logic             rte_wr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] ctl_rd_o,
  output logic [REG_W-1:0] rte_rd_o,
  input  logic [N_CMP-1:0] cmp_raw_i,
  input  logic [N_CMP-1:0] port_latch_i,
  input  logic             idle_i,
  input  logic             pdown_i,
  input  logic             irq_clr_i,
  output logic [N_CMP-1:0] cmp_en_o,
  output logic [N_CMP-1:0] in_pullup_off_o,
  output logic [N_CMP-1:0] cap_trig_o,
  output logic [N_CMP-1:0] pin_pullup_off_o,
  output logic [N_CMP-1:0] pin_pull_low_o,
  output logic             irq_o
);
  pmode_e           mode;
  logic [N_CMP-1:0] en_bits, cap_route, pin_route;
  logic [N_CMP-1:0] res_sync, eff_en, res;

  always_comb mode = decode_mode(idle_i, pdown_i);

  cmp_sync #(.WIDTH(N_CMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_raw_i),
    .q_o   (res_sync)
  );

  cmp_regs #(.N_CMP(N_CMP)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr_i    (ctl_wr_i),
    .ctl_data_i  (wr_data_i[REG_W-1:N_CMP]),
    .rte_wr_i    (rte_wr_i),
    .rte_data_i  (wr_data_i),
    .en_bits_o   (en_bits),
    .cap_route_o (cap_route),
    .pin_route_o (pin_route)
  );

  cmp_route #(.N_CMP(N_CMP)) u_route (
    .mode_i      (mode),
    .en_bits_i   (en_bits),
    .cap_route_i (cap_route),
    .pin_route_i (pin_route),
    .latch_i     (port_latch_i),
    .res_sync_i  (res_sync),
    .eff_en_o    (eff_en),
    .res_o       (res),
    .cap_trig_o  (cap_trig_o),
    .pin_own_o   (pin_pullup_off_o),
    .pin_low_o   (pin_pull_low_o)
  );

  cmp_irq #(.N_CMP(N_CMP)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_sync_i (res_sync),
    .eff_en_i   (eff_en),
    .clr_i      (irq_clr_i),
    .irq_o      (irq_o)
  );

  assign cmp_en_o        = eff_en;
  assign in_pullup_off_o = eff_en;
  assign ctl_rd_o        = {en_bits, res};
  assign rte_rd_o        = {cap_route, pin_route};
endmodule

// File: rtl/cmp_route_ctrl_chk.sv
module cmp_route_ctrl_chk #(
  parameter int unsigned N_CMP = 4,
  localparam int unsigned REG_W = 2 * N_CMP
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle_i,
  input logic             pdown_i,
  input logic             irq_clr_i,
  input logic [N_CMP-1:0] port_latch_i,
  input logic [REG_W-1:0] ctl_rd_o,
  input logic [N_CMP-1:0] cmp_en_o,
  input logic [N_CMP-1:0] cap_trig_o,
  input logic [N_CMP-1:0] pin_pullup_off_o,
  input logic [N_CMP-1:0] pin_pull_low_o,
  input logic             irq_o
);
  assert_pdown_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_i |-> (cmp_en_o == '0) && (pin_pullup_off_o == '0));

  assert_idle_no_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |-> (cap_trig_o == '0));

  assert_result_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd_o[N_CMP-1:0] & ~cmp_en_o) == '0);

  assert_low_needs_own_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pull_low_o & ~pin_pullup_off_o) == '0);

  assert_latch_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pullup_off_o & ~port_latch_i) == '0);

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);

  assert_irq_no_set_pdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && pdown_i) |=> !irq_o);
endmodule

bind cmp_route_ctrl cmp_route_ctrl_chk #(.N_CMP(N_CMP)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .idle_i           (idle_i),
  .pdown_i          (pdown_i),
  .irq_clr_i        (irq_clr_i),
  .port_latch_i     (port_latch_i),
  .ctl_rd_o         (ctl_rd_o),
  .cmp_en_o         (cmp_en_o),
  .cap_trig_o       (cap_trig_o),
  .pin_pullup_off_o (pin_pullup_off_o),
  .pin_pull_low_o   (pin_pull_low_o),
  .irq_o            (irq_o)
);

// File: tb/tb_cmp_route_ctrl.sv
`timescale 1ns/1ps
module tb_cmp_route_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr_i = 0, rte_wr_i = 0, idle_i = 0, pdown_i = 0, irq_clr_i = 0;
  logic [7:0] wr_data_i = '0;
  logic [3:0] cmp_raw_i = '0, port_latch_i = '0;
  logic [7:0] ctl_rd_o, rte_rd_o;
  logic [3:0] cmp_en_o, in_pullup_off_o, cap_trig_o, pin_pullup_off_o, pin_pull_low_o;
  logic       irq_o;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  cmp_route_ctrl dut (.*);

  // Behavioural reference: raw history queue gives the two-edge delay.
  logic [3:0] hist[$];
  logic [3:0] m_ctl = '0, m_prev = '0;
  logic [7:0] m_rte = '0;
  logic       m_irq = 1'b0;

  function automatic logic [3:0] m_sync();
    return (hist.size() >= 2) ? hist[1] : 4'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {};
      m_ctl = '0; m_rte = '0; m_prev = '0; m_irq = 1'b0;
    end else begin
      logic [3:0] en, s, rise;
      en   = pdown_i ? 4'h0 : m_ctl;
      s    = m_sync();
      rise = s & ~m_prev & en;
      if (rise != 0)      m_irq = 1'b1;
      else if (irq_clr_i) m_irq = 1'b0;
      m_prev = s;
      hist.push_front(cmp_raw_i);
      if (hist.size() > 2) void'(hist.pop_back());
      if (ctl_wr_i) m_ctl = wr_data_i[7:4];
      if (rte_wr_i) m_rte = wr_data_i;
    end
  end

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [3:0] en, s, res, own;
    en  = pdown_i ? 4'h0 : m_ctl;
    s   = m_sync();
    res = s & en;
    own = en & m_rte[3:0] & port_latch_i;
    chk("R2", "ctl_rd_en",  {4'h0, ctl_rd_o[7:4]}, {4'h0, m_ctl});
    chk("R3", "ctl_rd_res", {4'h0, ctl_rd_o[3:0]}, {4'h0, res});
    chk("R4", "cmp_en",     {4'h0, cmp_en_o}, {4'h0, en});
    chk("R4", "in_pullup",  {4'h0, in_pullup_off_o}, {4'h0, en});
    chk("R6", "cap_trig",   {4'h0, cap_trig_o},
        {4'h0, (idle_i || pdown_i) ? 4'h0 : (res & m_rte[7:4])});
    chk("R7", "pin_pullup_off", {4'h0, pin_pullup_off_o}, {4'h0, own});
    chk("R8", "pin_pull_low",   {4'h0, pin_pull_low_o}, {4'h0, own & ~s});
    chk("R9", "irq", {7'h0, irq_o}, {7'h0, m_irq});
    chk("R10", "rte_rd", rte_rd_o, m_rte);
    if (pdown_i) chk("R5", "pdown_outputs",
                     {cmp_en_o, cap_trig_o | pin_pullup_off_o}, 8'h00);
  endtask

  // Compare on every falling edge, before new stimulus is applied.
  bit run_checks = 0;
  always @(negedge clk) if (run_checks) compare_all();

  task automatic cyc();
    @(negedge clk); #0.1;
  endtask

  task automatic random_phase(int n, bit idl, bit pd);
    for (int k = 0; k < n; k++) begin
      cyc();
      idle_i       = idl;
      pdown_i      = pd;
      cmp_raw_i    = 4'($urandom);
      port_latch_i = 4'($urandom);
      irq_clr_i    = ($urandom % 6) == 0;
      ctl_wr_i     = ($urandom % 9) == 0;
      rte_wr_i     = ($urandom % 9) == 0;
      wr_data_i    = 8'($urandom);
    end
    cyc();
    ctl_wr_i = 0; rte_wr_i = 0; irq_clr_i = 0;
  endtask

  bit done = 0;
  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state while reset held
    #0.1;
    chk("R1", "ctl_rd_reset", ctl_rd_o, 8'h00);
    chk("R1", "rte_rd_reset", rte_rd_o, 8'h00);
    chk("R1", "outputs_reset", {cmp_en_o, cap_trig_o | pin_pullup_off_o | pin_pull_low_o}, 8'h00);
    chk("R1", "irq_reset", {7'h0, irq_o}, 8'h00);
    cyc(); rst_n = 1'b1; run_checks = 1;

    // R2: low control bits ignored on write
    cyc(); ctl_wr_i = 1; wr_data_i = 8'h5F;
    cyc(); ctl_wr_i = 0; cmp_raw_i = 4'hF;
    cyc(); chk("R2", "ctl_low_ignored", {ctl_rd_o[7:4], 4'h0}, 8'h50);
    // R3: result visible after two edges, masked where disabled (0x5 & 0xF)
    cyc(); chk("R3", "res_after_sync", {4'h0, ctl_rd_o[3:0]}, 8'h05);
    // R9: enabled rising edge sets irq
    cyc(); chk("R9", "irq_set", {7'h0, irq_o}, 8'h01);
    irq_clr_i = 1;
    cyc(); irq_clr_i = 0; chk("R9", "irq_cleared", {7'h0, irq_o}, 8'h00);
    // R7: pin route with latch set, result high -> own, not low
    rte_wr_i = 1; wr_data_i = 8'hFF; port_latch_i = 4'hF;
    cyc(); rte_wr_i = 0;
    chk("R7", "pin_own", {4'h0, pin_pullup_off_o}, 8'h05);
    chk("R7", "pin_not_low", {4'h0, pin_pull_low_o}, 8'h00);
    // R8: latch cleared releases pin
    port_latch_i = 4'h0; #0.1;
    chk("R8", "latch_release", {4'h0, pin_pullup_off_o}, 8'h00);
    // R5: power-down kills everything
    pdown_i = 1; #0.1;
    chk("R5", "pdown_en", {4'h0, cmp_en_o}, 8'h00);
    pdown_i = 0;

    random_phase(600, 0, 0);
    random_phase(400, 1, 0);
    random_phase(400, 0, 1);
    random_phase(200, 1, 1);
    random_phase(400, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule